// File: doc/BRIEF.md
# SPI Frame Counter and Interrupt Unit

This unit sits beside the shift engine of an SPI controller and turns transfer events into interrupt status. It counts completed frames against a programmable frame limit. When the limit is reached it raises the two done sources and asks the transfer logic to insert idle cycles on the bus, through a pause output, until software restarts the count. A second counter runs only while slave select is active. It counts the frames of each packet against a command size and raises a command source once per packet.

Six raw status bits latch their events. Each bit is ANDed with its enable to form masked status, and a write of ones to the clear vector drops the selected bits. A registered OR of the masked bits drives the interrupt line. Register decode and the serial data path sit outside this block. The block sees only the strobes and levels that those parts produce.

Top module: `spi_frame_irq`

## Requirements
- R1: Status bit index map: 0 transmit done, 1 receive ready, 2 receive overflow, 3 transmit underrun, 4 command size reached, 5 slave select ended. A pulse on `rx_ovf` or `tx_urun` sets bit 2 or bit 3 at the next clock edge, and the bit holds until cleared. All status bits are zero after reset.
- R2: A cycle with `clr_wr` high clears exactly the raw bits whose `clr_mask` bit is one. The other bits are untouched.
- R3: When an event and a clear of the same bit fall in the same cycle, the event wins and the bit stays set.
- R4: `mask_stat` equals `raw_stat` ANDed with `irq_en`, bit by bit, in the same cycle.
- R5: `irq` is a register that shows, one clock edge later, whether any `mask_stat` bit is set.
- R6: With the counter in use, the frame that brings the internal count up to the limit sets bits 0 and 1, and `pause` is high from the following cycle. Earlier frames set neither. The limit resets to 1, and a written limit of 0 acts as 1.
- R7: While `pause` is high, further frames are ignored: `pause` stays high and bits 0 and 1 are not set again.
- R8: The frame count returns to zero on `cnt_clr`, on `limit_wr`, and in any cycle with `core_en` low, so `pause` is low in the next cycle. Each of these wins over a frame in the same cycle.
- R9: With `ctr_off` high the limit is not used: `pause` stays low and every frame sets bits 0 and 1.
- R10: While `ss_n` is low, frames are counted per packet. The frame that reaches `cmd_size` sets bit 4. A size of 0 never sets it.
- R11: Bit 4 is set at most once per packet. The packet count restarts after `ss_n` goes high.
- R12: A rise of `ss_n` (select going inactive) sets bit 5. A fall does not.
- R13: With `core_en` low, frame strobes are ignored by both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_en | input | 1 | Core enabled; low flushes the frame count and ignores frames |
| ctr_off | input | 1 | Turns the frame limit off |
| cnt_clr | input | 1 | Clear-count command strobe |
| limit_wr | input | 1 | Frame limit write strobe |
| limit_val | input | LIMIT_W | New frame limit |
| cmd_size | input | CMD_W | Frames per packet before the command source fires |
| frame_done | input | 1 | One frame completed |
| ss_n | input | 1 | Slave select level, active low |
| rx_ovf | input | 1 | Receive overflow event |
| tx_urun | input | 1 | Transmit underrun event |
| irq_en | input | 6 | Per-source enables |
| clr_wr | input | 1 | Clear write strobe |
| clr_mask | input | 6 | Write-one-to-clear vector |
| raw_stat | output | 6 | Raw status |
| mask_stat | output | 6 | Masked status |
| pause | output | 1 | Frame limit reached; insert idle cycles |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The frame limit is swept from 0 to 5. Each setting runs two frames past the limit, which separates an off-by-one in the compare from a failure to saturate, and shows the zero-limit case. Packets of 0 to 5 frames are run against command sizes 0 to 4. This separates firing too early, too late, or for size zero, and a second packet shows the once-per-packet flag and its rearm. All 64 clear vectors are applied to a fully set status with a varying enable pattern, which catches any cross-wired clear or mask bit and the one-cycle lag of the interrupt. Single cases cover clear against event, disable, and limit writes made mid-count.

// File: rtl/spi_frame_irq_pkg.sv
package spi_frame_irq_pkg;
  localparam int NSRC       = 6;
  localparam int SRC_TXDONE = 0;
  localparam int SRC_RXRDY  = 1;
  localparam int SRC_RXOVF  = 2;
  localparam int SRC_TXURUN = 3;
  localparam int SRC_CMD    = 4;
  localparam int SRC_SSEND  = 5;

  // new events override a clear of the same bit
  function automatic logic [NSRC-1:0] next_raw(input logic [NSRC-1:0] raw,
                                               input logic [NSRC-1:0] set,
                                               input logic [NSRC-1:0] clr);
    return (raw & ~clr) | set;
  endfunction
endpackage

// File: rtl/sfi_limit_ctr.sv
module sfi_limit_ctr #(
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               core_en,
  input  logic               ctr_off,
  input  logic               cnt_clr,
  input  logic               limit_wr,
  input  logic [LIMIT_W-1:0] limit_val,
  input  logic               frame_done,
  output logic               reach,
  output logic               each,
  output logic               pause
);
  function automatic logic [LIMIT_W-1:0] eff_lim(input logic [LIMIT_W-1:0] v);
    return (v == '0) ? LIMIT_W'(1) : v;
  endfunction

  logic [LIMIT_W-1:0] lim_q, cnt_q, lim_eff;
  logic run, flush, at_lim;

  assign lim_eff = eff_lim(lim_q);
  assign run     = core_en && !ctr_off;
  assign flush   = cnt_clr || limit_wr || !core_en;
  assign at_lim  = (cnt_q == lim_eff);
  assign reach   = run && !flush && frame_done && !at_lim &&
                   ((cnt_q + LIMIT_W'(1)) == lim_eff);
  assign each    = core_en && ctr_off && frame_done;
  assign pause   = run && at_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= LIMIT_W'(1);
      cnt_q <= '0;
    end else begin
      if (limit_wr) lim_q <= limit_val;
      if (flush) cnt_q <= '0;
      else if (run && frame_done && !at_lim) cnt_q <= cnt_q + LIMIT_W'(1);
    end
  end
endmodule

// File: rtl/sfi_packet_ctr.sv
module sfi_packet_ctr #(
  parameter int CMD_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ss_act,
  input  logic             frame_ok,
  input  logic [CMD_W-1:0] cmd_size,
  output logic             cmd_hit,
  output logic             ss_end
);
  logic [CMD_W-1:0] cnt_q;
  logic             fired_q, ss_q;

  assign cmd_hit = ss_act && frame_ok && !fired_q && (cmd_size != '0) &&
                   ((cnt_q + CMD_W'(1)) == cmd_size);
  assign ss_end  = ss_q && !ss_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      ss_q    <= 1'b0;
    end else begin
      ss_q <= ss_act;
      if (!ss_act) begin
        cnt_q   <= '0;
        fired_q <= 1'b0;
      end else begin
        if (frame_ok && (cnt_q != '1)) cnt_q <= cnt_q + CMD_W'(1);
        if (cmd_hit) fired_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sfi_irq_regs.sv
module sfi_irq_regs import spi_frame_irq_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic            clr_wr,
  input  logic [NSRC-1:0] clr_mask,
  input  logic [NSRC-1:0] irq_en,
  output logic [NSRC-1:0] raw_stat,
  output logic [NSRC-1:0] mask_stat,
  output logic            irq
);
  logic [NSRC-1:0] clr_eff;

  assign clr_eff   = clr_wr ? clr_mask : '0;
  assign mask_stat = raw_stat & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_stat <= '0;
      irq      <= 1'b0;
    end else begin
      raw_stat <= next_raw(raw_stat, set_vec, clr_eff);
      irq      <= |mask_stat;
    end
  end
endmodule

// File: rtl/spi_frame_irq.sv
module spi_frame_irq import spi_frame_irq_pkg::*; #(
  parameter int LIMIT_W = 16,
  parameter int CMD_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               core_en,
  input  logic               ctr_off,
  input  logic               cnt_clr,
  input  logic               limit_wr,
  input  logic [LIMIT_W-1:0] limit_val,
  input  logic [CMD_W-1:0]   cmd_size,
  input  logic               frame_done,
  input  logic               ss_n,
  input  logic               rx_ovf,
  input  logic               tx_urun,
  input  logic [NSRC-1:0]    irq_en,
  input  logic               clr_wr,
  input  logic [NSRC-1:0]    clr_mask,
  output logic [NSRC-1:0]    raw_stat,
  output logic [NSRC-1:0]    mask_stat,
  output logic               pause,
  output logic               irq
);
  logic frame_reach, frame_each, cmd_hit, ss_end, frame_ok;
  logic [NSRC-1:0] set_vec;

  assign frame_ok = frame_done && core_en;

  sfi_limit_ctr #(.LIMIT_W(LIMIT_W)) u_limit (
    .clk(clk), .rst_n(rst_n), .core_en(core_en), .ctr_off(ctr_off),
    .cnt_clr(cnt_clr), .limit_wr(limit_wr), .limit_val(limit_val),
    .frame_done(frame_done), .reach(frame_reach), .each(frame_each),
    .pause(pause)
  );

  sfi_packet_ctr #(.CMD_W(CMD_W)) u_packet (
    .clk(clk), .rst_n(rst_n), .ss_act(!ss_n), .frame_ok(frame_ok),
    .cmd_size(cmd_size), .cmd_hit(cmd_hit), .ss_end(ss_end)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[SRC_TXDONE] = frame_reach || frame_each;
    set_vec[SRC_RXRDY]  = frame_reach || frame_each;
    set_vec[SRC_RXOVF]  = rx_ovf;
    set_vec[SRC_TXURUN] = tx_urun;
    set_vec[SRC_CMD]    = cmd_hit;
    set_vec[SRC_SSEND]  = ss_end;
  end

  sfi_irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_wr(clr_wr),
    .clr_mask(clr_mask), .irq_en(irq_en), .raw_stat(raw_stat),
    .mask_stat(mask_stat), .irq(irq)
  );
endmodule

// File: rtl/spi_frame_irq_chk.sv
module spi_frame_irq_chk import spi_frame_irq_pkg::*; (
  input logic            clk,
  input logic            rst_n,
  input logic            core_en,
  input logic            ctr_off,
  input logic            cnt_clr,
  input logic            limit_wr,
  input logic            frame_done,
  input logic            ss_n,
  input logic            rx_ovf,
  input logic            tx_urun,
  input logic            clr_wr,
  input logic [NSRC-1:0] clr_mask,
  input logic [NSRC-1:0] raw_stat,
  input logic [NSRC-1:0] mask_stat,
  input logic            pause,
  input logic            irq,
  input logic            frame_reach,
  input logic            cmd_hit
);
  // R1
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |=> raw_stat[SRC_RXOVF]);
  // R2
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_mask[SRC_RXOVF] && !rx_ovf) |=> !raw_stat[SRC_RXOVF]);
  // R3
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_urun && clr_wr && clr_mask[SRC_TXURUN]) |=> raw_stat[SRC_TXURUN]);
  // R5
  irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |$past(mask_stat)));
  // R6
  reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_reach |=> (raw_stat[SRC_TXDONE] && raw_stat[SRC_RXRDY] &&
                     (pause || ctr_off || !core_en)));
  // R7
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && frame_done && !cnt_clr && !limit_wr) |=> (pause || ctr_off || !core_en));
  // R8
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clr || limit_wr) |=> !pause);
  // R10
  cmd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |=> raw_stat[SRC_CMD]);
  // R11
  cmd_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |=> !cmd_hit);
  // R12
  ss_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n) |=> raw_stat[SRC_SSEND]);
endmodule

bind spi_frame_irq spi_frame_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .core_en(core_en), .ctr_off(ctr_off),
  .cnt_clr(cnt_clr), .limit_wr(limit_wr), .frame_done(frame_done),
  .ss_n(ss_n), .rx_ovf(rx_ovf), .tx_urun(tx_urun), .clr_wr(clr_wr),
  .clr_mask(clr_mask), .raw_stat(raw_stat), .mask_stat(mask_stat),
  .pause(pause), .irq(irq), .frame_reach(frame_reach), .cmd_hit(cmd_hit)
);

// File: tb/spi_frame_irq_bench.sv
module spi_frame_irq_bench;
  localparam int LW = 16;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n, core_en, ctr_off, cnt_clr, limit_wr, frame_done, ss_n;
  logic rx_ovf, tx_urun, clr_wr, pause, irq;
  logic [LW-1:0] limit_val;
  logic [CW-1:0] cmd_size;
  logic [5:0] irq_en, clr_mask, raw_stat, mask_stat;
  int n_chk = 0;
  int n_bad = 0;
  bit done_run = 1'b0;

  always #10 clk = ~clk;

  spi_frame_irq #(.LIMIT_W(LW), .CMD_W(CW)) u_spi_frame_irq (
    .clk(clk), .rst_n(rst_n), .core_en(core_en), .ctr_off(ctr_off),
    .cnt_clr(cnt_clr), .limit_wr(limit_wr), .limit_val(limit_val),
    .cmd_size(cmd_size), .frame_done(frame_done), .ss_n(ss_n),
    .rx_ovf(rx_ovf), .tx_urun(tx_urun), .irq_en(irq_en), .clr_wr(clr_wr),
    .clr_mask(clr_mask), .raw_stat(raw_stat), .mask_stat(mask_stat),
    .pause(pause), .irq(irq)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse_frame();
    frame_done = 1'b1; tick(); frame_done = 1'b0;
  endtask

  task automatic wr_limit(input int v);
    limit_val = LW'(v); limit_wr = 1'b1; tick(); limit_wr = 1'b0;
  endtask

  task automatic clr(input logic [5:0] m);
    clr_mask = m; clr_wr = 1'b1; tick(); clr_wr = 1'b0; clr_mask = '0;
  endtask

  task automatic ctr_clear();
    cnt_clr = 1'b1; tick(); cnt_clr = 1'b0;
  endtask

  task automatic set_all();
    ctr_off = 1'b1; cmd_size = CW'(1); ss_n = 1'b0; tick();
    pulse_frame();
    ss_n = 1'b1; tick();
    rx_ovf = 1'b1; tx_urun = 1'b1; tick(); rx_ovf = 1'b0; tx_urun = 1'b0;
    chk("R1 all sources set", raw_stat, 6'h3F);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_run) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; core_en = 0; ctr_off = 0; cnt_clr = 0; limit_wr = 0;
    limit_val = '0; cmd_size = '0; frame_done = 0; ss_n = 1;
    rx_ovf = 0; tx_urun = 0; irq_en = '0; clr_wr = 0; clr_mask = '0;
    repeat (3) tick();
    rst_n = 1; tick();
    chk("R1 reset raw", raw_stat, 0);
    chk("R8 reset pause", pause, 0);
    chk("R5 reset irq", irq, 0);
    core_en = 1; tick();

    // R6: reset limit is one
    pulse_frame();
    chk("R6 reset limit pause", pause, 1);
    chk("R6 reset limit done", raw_stat[1:0], 3);
    clr(6'h03); ctr_clear();

    // R6/R7/R8 limit sweep
    for (int lim = 0; lim <= 5; lim++) begin
      int eff;
      eff = (lim == 0) ? 1 : lim;
      wr_limit(lim);
      for (int f = 1; f <= eff + 2; f++) begin
        pulse_frame();
        chk("R6 pause", pause, (f >= eff) ? 1 : 0);
        chk("R6 done bits", raw_stat[1:0], (f >= eff) ? 3 : 0);
      end
      clr(6'h03);
      pulse_frame();
      chk("R7 frame ignored", raw_stat[1:0], 0);
      chk("R7 pause held", pause, 1);
      ctr_clear();
      chk("R8 clear command", pause, 0);
    end

    // R8 limit write mid-count
    wr_limit(3); pulse_frame(); pulse_frame();
    wr_limit(3); pulse_frame(); pulse_frame();
    chk("R8 limit write restarts", pause, 0);
    pulse_frame();
    chk("R8 count after rewrite", pause, 1);
    clr(6'h3F); ctr_clear();
    // R8 disable mid-count, and R8 clear beats frame
    wr_limit(2); pulse_frame();
    core_en = 0; tick(); core_en = 1;
    pulse_frame();
    chk("R8 disable restarts", pause, 0);
    frame_done = 1; cnt_clr = 1; tick(); frame_done = 0; cnt_clr = 0;
    pulse_frame();
    chk("R8 clear beats frame", pause, 0);
    pulse_frame();
    chk("R8 after clear", pause, 1);
    clr(6'h3F); ctr_clear();

    // R13 disabled core ignores frames
    core_en = 0; wr_limit(1); cmd_size = CW'(1); ss_n = 0; tick();
    pulse_frame(); pulse_frame();
    chk("R13 no done bits", raw_stat[1:0], 0);
    chk("R13 no cmd bit", raw_stat[4], 0);
    chk("R13 no pause", pause, 0);
    ss_n = 1; tick(); clr(6'h3F); core_en = 1; tick();

    // R9 counter off
    ctr_off = 1; wr_limit(1);
    pulse_frame();
    chk("R9 done on frame", raw_stat[1:0], 3);
    clr(6'h03);
    pulse_frame(); pulse_frame();
    chk("R9 done again", raw_stat[1:0], 3);
    chk("R9 no pause", pause, 0);
    clr(6'h3F);

    // R10/R12 packet sweep
    for (int sz = 0; sz <= 4; sz++) begin
      for (int len = 0; len <= 5; len++) begin
        cmd_size = CW'(sz);
        clr(6'h3F);
        ss_n = 0; tick();
        chk("R12 fall no set", raw_stat[5], 0);
        repeat (len) pulse_frame();
        chk("R10 cmd bit", raw_stat[4], (sz != 0 && len >= sz) ? 1 : 0);
        ss_n = 1; tick();
        chk("R12 rise sets", raw_stat[5], 1);
      end
    end
    clr(6'h3F);

    // R11 once per packet, rearm
    cmd_size = CW'(2); ss_n = 0; tick();
    pulse_frame(); pulse_frame();
    chk("R11 first hit", raw_stat[4], 1);
    clr(6'h10);
    pulse_frame(); pulse_frame();
    chk("R11 no second hit", raw_stat[4], 0);
    ss_n = 1; tick(); ss_n = 0; tick();
    pulse_frame(); pulse_frame();
    chk("R11 rearmed", raw_stat[4], 1);
    ss_n = 1; tick(); clr(6'h3F);

    // R2/R4/R5 sweep of clear vectors and enables
    for (int m = 0; m < 64; m++) begin
      logic [5:0] e, expv;
      irq_en = '0;
      set_all();
      clr(6'(m));
      chk("R2 clear selected", raw_stat, (~m) & 6'h3F);
      tick();
      e = 6'((m * 5 + 3) & 63);
      expv = 6'(~m) & e;
      irq_en = e; #1;
      chk("R4 masked", mask_stat, expv);
      chk("R5 irq not yet", irq, 0);
      tick();
      chk("R5 irq registered", irq, |expv);
    end
    irq_en = '0; clr(6'h3F); tick();

    // R3 event beats clear
    rx_ovf = 1; clr_mask = 6'h3F; clr_wr = 1; tick();
    rx_ovf = 0; clr_wr = 0; clr_mask = '0;
    chk("R3 event wins", raw_stat, 6'h04);
    tx_urun = 1; clr_mask = 6'h08; clr_wr = 1; tick();
    tx_urun = 0; clr_wr = 0; clr_mask = '0;
    chk("R3 other bit kept", raw_stat, 6'h0C);
    clr(6'h04);
    chk("R2 single clear", raw_stat, 6'h08);

    done_run = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule